// File: doc/BRIEF.md
# Shift and Rotate Micro-operation Unit

This unit executes the shift and rotate family of integer micro-operations on an operand of 1, 2, 4 or 8 bytes. It provides three plain shifts: left, logical right and arithmetic right. It provides two plain rotates, right and left. It also provides two rotates that pass through the carry flag. The shift count comes either from the second source register or from an 8-bit immediate. The count is masked to a width that depends on the operand size.

The result of each operation is written into the low operand-size bytes of the old destination value, and the bytes above keep their old contents. A rotate whose masked count is zero, or the reserved operation code, leaves the whole old destination value in place.

Each operation is issued with a one-cycle `valid_i` pulse. The merged result is registered and appears one clock later, together with `valid_o`.

Top module: `shift_rot_unit`

## Requirements
- R1: The operand size code `size_i` selects the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The effective count n keeps the low 6 bits of the count source when the size code is 3, and the low 5 bits for every other size code.
- R2: When `use_imm_i` is 1, the count source is `imm_i` zero-extended. When it is 0, the count source is `src2_i`.
- R3: Op code 0 is a left shift. Result bit i equals src1 bit i-n, and zero where i-n < 0. With n of at least the width W, the operand field is zero.
- R4: Op code 1 is a logical right shift. Vacated upper bits within W are zero, and with n >= W the field is zero.
- R5: Op code 2 is an arithmetic right shift. Vacated bits within W copy src1 bit W-1, and with n >= W the whole field equals that bit.
- R6: Op codes 3 and 4 rotate the low W bits of src1 right and left by n modulo W. When n is a non-zero multiple of W, the result is src1 unchanged.
- R7: Op code 5 rotates the (W+1)-bit value {cf_i, src1[W-1:0]} right by k = n mod (W+1) and keeps the low W bits. For 1 <= k <= W, this puts the carry at bit W-k, with the low k-1 source bits directly above it.
- R8: Op code 6 rotates the same (W+1)-bit value left by k = n mod (W+1) and keeps the low W bits. This puts the carry at bit k-1, with the top k-1 source bits directly below it.
- R9: For op codes 3 to 6, a masked count of zero returns all 64 bits of `dest_i` unchanged.
- R10: Bytes of the result at and above the operand size are taken from `dest_i`.
- R11: Op code 7 returns `dest_i` unchanged.
- R12: During reset, `valid_o` and `result_o` are 0. A `valid_i` pulse gives `valid_o` high and the result one cycle later. Without `valid_i`, `valid_o` is low and `result_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code (R3 to R8, R11) |
| size_i | input | 2 | Operand size code |
| use_imm_i | input | 1 | Take the count from the immediate |
| imm_i | input | 8 | Immediate count |
| src1_i | input | 64 | Value to shift or rotate |
| src2_i | input | 64 | Register count source |
| dest_i | input | 64 | Old destination value |
| cf_i | input | 1 | Carry flag for the through-carry rotates |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Merged result |

## Verification
The bench uses random operands, sizes and counts. The counts come from both sources and are biased toward small values, so the masking and modulo paths are hit often. Directed cases then isolate single effects. Counts equal to or beyond a narrow width tell zero fill apart from sign fill. A byte rotate by 8, or a through-carry rotate by 9, tells proper modulo reduction apart from a plain shift. An immediate of 32 at 4 bytes, or 64 at 8 bytes, tells a masked-zero hold apart from a full rotation. A 0x80 source with a set carry tells apart where the carry lands in each direction.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;
  typedef enum logic [2:0] {
    SR_SLL = 3'd0,
    SR_SRL = 3'd1,
    SR_SRA = 3'd2,
    SR_ROR = 3'd3,
    SR_ROL = 3'd4,
    SR_RCR = 3'd5,
    SR_RCL = 3'd6,
    SR_NOP = 3'd7
  } sr_op_e;

  function automatic logic is_rotate(sr_op_e op);
    return (op == SR_ROR) || (op == SR_ROL) || (op == SR_RCR) || (op == SR_RCL);
  endfunction
endpackage

// File: rtl/shift_rot_count.sv
module shift_rot_count #(
  parameter int XLEN = 64,
  parameter int IMMW = 8,
  parameter int SZW  = 2,
  parameter int CW   = 6
) (
  input  logic [XLEN-1:0] src2_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            use_imm_i,
  input  logic [SZW-1:0]  size_i,
  output logic [CW-1:0]   cnt_o
);
  logic [CW-1:0] raw;
  logic          widest;

  assign raw    = use_imm_i ? CW'(imm_i) : src2_i[CW-1:0];
  assign widest = (size_i == {SZW{1'b1}});
  // narrower sizes drop the top count bit
  assign cnt_o  = widest ? raw : {1'b0, raw[CW-2:0]};
endmodule

// File: rtl/shift_rot_lane.sv
module shift_rot_lane
  import shift_rot_pkg::*;
#(
  parameter int LW = 8,
  parameter int CW = 6
) (
  input  sr_op_e        op_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [LW-1:0] src_i,
  input  logic          cf_i,
  output logic [LW-1:0] res_o
);
  localparam int RW    = CW + 2;
  localparam int STEPS = (1 << CW) / LW + 1;

  function automatic logic [RW-1:0] mod_red(input logic [RW-1:0] v, input logic [RW-1:0] m);
    logic [RW-1:0] r;
    r = v;
    for (int s = 0; s < STEPS; s++) begin
      if (r >= m) r = r - m;
    end
    return r;
  endfunction

  logic [RW-1:0]     n, k_rot, k_rc;
  logic              big;
  logic [LW-1:0]     sll_w, srl_w, sra_w;
  logic signed [LW-1:0] s_src;
  logic [2*LW-1:0]   dbl, ror_d, rol_d;
  logic [LW:0]       xc;
  logic [2*LW+1:0]   dbl_c, rcr_d, rcl_d;

  assign n     = RW'(cnt_i);
  assign k_rot = mod_red(n, RW'(LW));
  assign k_rc  = mod_red(n, RW'(LW + 1));
  assign big   = (n >= RW'(LW));

  assign sll_w = src_i << n;
  assign srl_w = src_i >> n;
  assign s_src = src_i;
  assign sra_w = s_src >>> n;

  assign dbl   = {src_i, src_i};
  assign ror_d = dbl >> k_rot;
  assign rol_d = dbl << k_rot;

  assign xc    = {cf_i, src_i};
  assign dbl_c = {xc, xc};
  assign rcr_d = dbl_c >> k_rc;
  assign rcl_d = dbl_c << k_rc;

  always_comb begin
    unique case (op_i)
      SR_SLL:  res_o = big ? '0 : sll_w;
      SR_SRL:  res_o = big ? '0 : srl_w;
      SR_SRA:  res_o = big ? {LW{src_i[LW-1]}} : sra_w;
      SR_ROR:  res_o = ror_d[LW-1:0];
      SR_ROL:  res_o = rol_d[2*LW-1:LW];
      SR_RCR:  res_o = rcr_d[LW-1:0];
      SR_RCL:  res_o = rcl_d[2*LW:LW+1];
      default: res_o = src_i;
    endcase
  end
endmodule

// File: rtl/shift_rot_merge.sv
module shift_rot_merge #(
  parameter int XLEN = 64,
  parameter int SZW  = 2
) (
  input  logic [XLEN-1:0] dest_i,
  input  logic [XLEN-1:0] lane_i,
  input  logic [SZW-1:0]  size_i,
  input  logic            hold_i,
  output logic [XLEN-1:0] res_o
);
  localparam int NB = XLEN / 8;
  localparam int BW = $clog2(NB) + 1;

  logic [BW-1:0] nbytes;
  assign nbytes = BW'(1) << size_i;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign res_o[8*b +: 8] = (hold_i || (BW'(b) >= nbytes)) ? dest_i[8*b +: 8] : lane_i[8*b +: 8];
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [1:0]      size_i,
  input  logic            use_imm_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  input  logic [XLEN-1:0] dest_i,
  input  logic            cf_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o
);
  localparam int NSZ = $clog2(XLEN / 8) + 1;
  localparam int SZW = 2;
  localparam int CW  = $clog2(XLEN);

  sr_op_e          op;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] lane_res [NSZ];
  logic [XLEN-1:0] sel_res, merged;
  logic            hold;
  logic            valid_q;
  logic [XLEN-1:0] res_q;

  assign op = sr_op_e'(op_i);

  shift_rot_count #(.XLEN(XLEN), .IMMW(IMMW), .SZW(SZW), .CW(CW)) u_count (
    .src2_i    (src2_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .size_i    (size_i),
    .cnt_o     (cnt)
  );

  for (genvar g = 0; g < NSZ; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] out;
    shift_rot_lane #(.LW(LW), .CW(CW)) u_lane (
      .op_i  (op),
      .cnt_i (cnt),
      .src_i (src1_i[LW-1:0]),
      .cf_i  (cf_i),
      .res_o (out)
    );
    assign lane_res[g] = XLEN'(out);
  end

  assign sel_res = lane_res[size_i];
  assign hold    = (op == SR_NOP) || (is_rotate(op) && (cnt == '0));

  shift_rot_merge #(.XLEN(XLEN), .SZW(SZW)) u_merge (
    .dest_i (dest_i),
    .lane_i (sel_res),
    .size_i (size_i),
    .hold_i (hold),
    .res_o  (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= merged;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  AST_CNT_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != 2'd3) |-> !cnt[CW-1]); // R1
  AST_ROT_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_rotate(op) && cnt == '0) |=> (result_o == $past(dest_i))); // R9
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0) |=> (result_o[XLEN-1:8] == $past(dest_i[XLEN-1:8]))); // R10
  AST_NOP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> (result_o == $past(dest_i))); // R11
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o))); // R12
endmodule

// File: tb/shift_rot_unit_bench.sv
`timescale 1ns/1ps
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic        use_imm = 1'b0;
  logic [7:0]  imm = '0;
  logic [63:0] src1 = '0, src2 = '0, dest = '0;
  logic        cf = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .use_imm_i(use_imm), .imm_i(imm), .src1_i(src1), .src2_i(src2),
    .dest_i(dest), .cf_i(cf), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] model(input logic [2:0] o, input logic [1:0] sz,
      input logic [63:0] s1, input logic [63:0] s2, input logic [7:0] im,
      input logic ui, input logic [63:0] d, input logic c);
    int w, n, k, len;
    logic [63:0] cs, r, out;
    logic [64:0] x;
    w   = 8 << sz;
    cs  = ui ? {56'b0, im} : s2;
    n   = int'(cs & ((sz == 2'd3) ? 64'd63 : 64'd31));
    r   = '0;
    x   = '0;
    out = d;
    if (o == 3'd7 || (o >= 3'd3 && n == 0)) return d;
    for (int i = 0; i < w; i++) x[i] = s1[i];
    x[w] = c;
    len = w + 1;
    for (int i = 0; i < w; i++) begin
      case (o)
        3'd0: r[i] = (i - n >= 0) ? s1[i-n] : 1'b0;
        3'd1: r[i] = (i + n < w) ? s1[i+n] : 1'b0;
        3'd2: r[i] = (i + n < w) ? s1[i+n] : s1[w-1];
        3'd3: begin k = n % w; r[i] = s1[(i + k) % w]; end
        3'd4: begin k = n % w; r[i] = s1[(i + w - k) % w]; end
        3'd5: begin k = n % len; r[i] = x[(i + k) % len]; end
        default: begin k = n % len; r[i] = x[(i + len - k) % len]; end
      endcase
    end
    for (int i = 0; i < w; i++) out[i] = r[i];
    return out;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [2:0] o, input logic [1:0] sz,
      input logic [63:0] s1, input logic [63:0] s2, input logic [7:0] im,
      input logic ui, input logic [63:0] d, input logic c);
    logic [63:0] exp;
    exp = model(o, sz, s1, s2, im, ui, d, c);
    @(negedge clk);
    op = o; size = sz; src1 = s1; src2 = s2; imm = im; use_imm = ui; dest = d; cf = c;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(req, result_o, exp);
    check("R12", {63'b0, valid_o}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R12", {63'b0, valid_o}, 64'd0);
    check("R12", result_o, 64'd0);
    rst_n = 1'b1;

    // R3 byte shift by width clears field, upper bytes kept (R10)
    run("R3", 3'd0, 2'd0, 64'hFF, 64'd8, 8'd0, 1'b0, 64'hAAAA_BBBB_CCCC_DD11, 1'b0);
    // R4 zero fill beyond width in 2-byte field
    run("R4", 3'd1, 2'd1, 64'hFFFF, 64'd0, 8'd20, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0);
    // R5 sign fill, count past width
    run("R5", 3'd2, 2'd0, 64'h80, 64'd9, 8'd0, 1'b0, 64'h0, 1'b0);
    run("R5", 3'd2, 2'd2, 64'h8000_0001, 64'd4, 8'd0, 1'b0, 64'hFFFF_FFFF_0000_0000, 1'b0);
    // R6 byte rotate by 8 returns source
    run("R6", 3'd3, 2'd0, 64'h5A, 64'd8, 8'd0, 1'b0, 64'h77, 1'b0);
    run("R6", 3'd4, 2'd3, 64'h8000_0000_0000_0001, 64'd0, 8'd1, 1'b1, 64'h0, 1'b0);
    // R1/R9 imm 32 at 4 bytes masks to zero -> hold
    run("R1", 3'd3, 2'd2, 64'h1, 64'd0, 8'd32, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 1'b0);
    run("R9", 3'd5, 2'd3, 64'h1, 64'd64, 8'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b1);
    // R1 8-byte count 0x7F masks to 63
    run("R1", 3'd0, 2'd3, 64'h1, 64'h7F, 8'd0, 1'b0, 64'h0, 1'b0);
    // R2 register count ignored when immediate selected
    run("R2", 3'd0, 2'd3, 64'h1, 64'd5, 8'd2, 1'b1, 64'h0, 1'b0);
    run("R2", 3'd0, 2'd3, 64'h1, 64'd5, 8'd2, 1'b0, 64'h0, 1'b0);
    // R7/R8 carry placement
    run("R7", 3'd5, 2'd0, 64'h00, 64'd1, 8'd0, 1'b0, 64'h0, 1'b1);
    run("R7", 3'd5, 2'd0, 64'h5A, 64'd9, 8'd0, 1'b0, 64'h0, 1'b1);
    run("R8", 3'd6, 2'd0, 64'h80, 64'd1, 8'd0, 1'b0, 64'h0, 1'b1);
    run("R8", 3'd6, 2'd1, 64'hC000, 64'd3, 8'd0, 1'b0, 64'h0, 1'b0);
    // R11 reserved code
    run("R11", 3'd7, 2'd3, 64'hFFFF, 64'd3, 8'd0, 1'b0, 64'h1357_9BDF_2468_ACE0, 1'b0);
    // R10 merge at 4 bytes
    run("R10", 3'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 8'd0, 1'b0, 64'h1111_2222_3333_4444, 1'b0);

    // R12 idle hold
    keep = result_o;
    @(negedge clk);
    src1 = 64'hFFFF; dest = 64'h9; op = 3'd0;
    @(negedge clk);
    check("R12", result_o, keep);
    check("R12", {63'b0, valid_o}, 64'd0);

    for (int t = 0; t < 3000; t++) begin
      logic [2:0]  ro;
      logic [1:0]  rs;
      logic [63:0] r1, r2, rd;
      logic [7:0]  ri;
      ro = 3'($urandom_range(0, 7));
      rs = 2'($urandom_range(0, 3));
      r1 = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      r2 = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 70));
      ri = 8'($urandom);
      run(req_of(ro), ro, rs, r1, r2, ri, 1'($urandom), rd, 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule